// File: doc/BRIEF.md
# Dual-stream element-wise adder

This block has two streaming inputs and one streaming output. Each input carries one 32-bit integer element per beat. The block takes one beat from each input, adds the two elements, and sends the sum out as one output beat. The last-beat marker on each stream marks the end of a frame. Valid/ready handshakes are honoured on all three ports, and the output may apply backpressure.

The two input frames can have different lengths. When one input reaches its frame end first, that input is parked and does not accept further beats. The other input keeps being accepted, and its remaining beats are thrown away, until it also presents its frame-end beat. After that, both inputs start the next frame together. The block therefore recovers from any loss of alignment without help from outside.

Each output frame ends on the paired beat where either input ended its frame. The sum wraps modulo 2^32. The output passes through a two-entry skid stage, so the input-side ready signals never depend combinationally on the output-side ready.

Top module: `stream_pair_adder`

## Requirements
- R1: Each output beat carries the 32-bit sum, modulo 2^32, of the two input elements that were accepted together.
- R2: While neither input is parked, a beat is accepted from one input only in a cycle in which a beat is also accepted from the other. Acceptance requires both inputs valid and room in the output stage.
- R3: The output byte-enable `m_tkeep` is all ones at all times, including during reset.
- R4: The output last marker is set exactly on the paired beat in which at least one input had its last marker set.
- R5: After an input delivers a last-marked beat in a pair where the other input was not last-marked, that input's ready stays low until the other input delivers a last-marked beat.
- R6: While one input is parked, the other input's ready is high whatever the output's readiness is. Beats accepted from it during this time produce no output beat.
- R7: Once the draining input delivers its last-marked beat, both inputs resume, and the next frames are paired from their first beats.
- R8: Input ready signals do not change when `m_tready` changes within a cycle. While `m_tvalid` is high and `m_tready` is low, the output data and last marker are held. Every paired sum leaves exactly once, in order.
- R9: While the synchronous active-low reset `rst_n` is low, the parked state is cleared and the output is emptied (`m_tvalid` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_tdata | input | 32 | First input element |
| a_tlast | input | 1 | First input frame-end marker |
| a_tvalid | input | 1 | First input beat valid |
| a_tready | output | 1 | First input beat accepted |
| b_tdata | input | 32 | Second input element |
| b_tlast | input | 1 | Second input frame-end marker |
| b_tvalid | input | 1 | Second input beat valid |
| b_tready | output | 1 | Second input beat accepted |
| m_tdata | output | 32 | Sum element |
| m_tkeep | output | 4 | Byte enables, constant all ones |
| m_tlast | output | 1 | Output frame-end marker |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |

## Verification
Two functions can fall in the same cycle: discarding beats from the draining input, and releasing held output beats under backpressure. Draining does not wait for output room, so the skid stage can be full and stalled while the longer input is still being consumed. The bench provokes this by sweeping every pair of frame lengths from one to four against random valid gaps and random output readiness. It judges the result with an arithmetic scoreboard that expects only the paired sums of the shorter frame, together with per-cycle checks of the parked input's ready and of output stability.

// File: rtl/spa_pkg.sv
package spa_pkg;
    // Alignment mode of the input pairing logic
    typedef enum logic [1:0] {
        ALIGN_PAIR   = 2'd0,  // both inputs accepted together
        ALIGN_PARK_A = 2'd1,  // input A parked at frame end, B draining
        ALIGN_PARK_B = 2'd2   // input B parked at frame end, A draining
    } align_e;

    typedef struct packed {
        align_e mode;
    } align_state_t;
endpackage

// File: rtl/spa_align_ctrl.sv
module spa_align_ctrl
    import spa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_tvalid,
    input  logic a_tlast,
    input  logic b_tvalid,
    input  logic b_tlast,
    input  logic up_ready,
    output logic a_tready,
    output logic b_tready,
    output logic pair_fire
);
    align_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        a_tready  = 1'b0;
        b_tready  = 1'b0;
        pair_fire = 1'b0;
        unique case (st_q.mode)
            ALIGN_PAIR: begin
                a_tready  = b_tvalid && up_ready;
                b_tready  = a_tvalid && up_ready;
                pair_fire = a_tvalid && b_tvalid && up_ready;
                if (pair_fire) begin
                    if (a_tlast && !b_tlast) begin
                        st_d.mode = ALIGN_PARK_A;
                    end else if (b_tlast && !a_tlast) begin
                        st_d.mode = ALIGN_PARK_B;
                    end
                end
            end
            ALIGN_PARK_A: begin
                b_tready = 1'b1;
                if (b_tvalid && b_tlast) begin
                    st_d.mode = ALIGN_PAIR;
                end
            end
            ALIGN_PARK_B: begin
                a_tready = 1'b1;
                if (a_tvalid && a_tlast) begin
                    st_d.mode = ALIGN_PAIR;
                end
            end
            default: st_d.mode = ALIGN_PAIR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= ALIGN_PAIR;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spa_pair_add.sv
module spa_pair_add #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_last,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_last,
    output logic [DATA_W-1:0] sum,
    output logic              sum_last
);
    // Wrapping addition: carry out is dropped
    always_comb begin
        sum      = a_data + b_data;
        sum_last = a_last || b_last;
    end
endmodule

// File: rtl/spa_skid.sv
module spa_skid #(
    parameter int PAY_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic [PAY_W-1:0] up_data,
    output logic             up_ready,
    output logic             dn_valid,
    output logic [PAY_W-1:0] dn_data,
    input  logic             dn_ready
);
    typedef struct packed {
        logic             main_v;
        logic [PAY_W-1:0] main_d;
        logic             spare_v;
        logic [PAY_W-1:0] spare_d;
    } skid_t;

    skid_t sk_d, sk_q;

    always_comb begin
        sk_d = sk_q;
        if (sk_q.spare_v) begin
            if (dn_ready) begin
                sk_d.main_d  = sk_q.spare_d;
                sk_d.main_v  = 1'b1;
                sk_d.spare_v = 1'b0;
            end
        end else if (up_valid) begin
            if (!sk_q.main_v || dn_ready) begin
                sk_d.main_v = 1'b1;
                sk_d.main_d = up_data;
            end else begin
                sk_d.spare_v = 1'b1;
                sk_d.spare_d = up_data;
            end
        end else if (dn_ready) begin
            sk_d.main_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= '0;
        end else begin
            sk_q <= sk_d;
        end
    end

    assign up_ready = !sk_q.spare_v;
    assign dn_valid = sk_q.main_v;
    assign dn_data  = sk_q.main_d;
endmodule

// File: rtl/stream_pair_adder.sv
module stream_pair_adder #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     a_tdata,
    input  logic                  a_tlast,
    input  logic                  a_tvalid,
    output logic                  a_tready,
    input  logic [DATA_W-1:0]     b_tdata,
    input  logic                  b_tlast,
    input  logic                  b_tvalid,
    output logic                  b_tready,
    output logic [DATA_W-1:0]     m_tdata,
    output logic [DATA_W/8-1:0]   m_tkeep,
    output logic                  m_tlast,
    output logic                  m_tvalid,
    input  logic                  m_tready
);
    localparam int KEEP_W = DATA_W / 8;
    localparam int PAY_W  = DATA_W + 1;

    logic              up_ready;
    logic              pair_fire;
    logic [DATA_W-1:0] sum;
    logic              sum_last;
    logic [PAY_W-1:0]  dn_pay;

    spa_align_ctrl u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_tvalid  (a_tvalid),
        .a_tlast   (a_tlast),
        .b_tvalid  (b_tvalid),
        .b_tlast   (b_tlast),
        .up_ready  (up_ready),
        .a_tready  (a_tready),
        .b_tready  (b_tready),
        .pair_fire (pair_fire)
    );

    spa_pair_add #(.DATA_W(DATA_W)) u_add (
        .a_data   (a_tdata),
        .a_last   (a_tlast),
        .b_data   (b_tdata),
        .b_last   (b_tlast),
        .sum      (sum),
        .sum_last (sum_last)
    );

    spa_skid #(.PAY_W(PAY_W)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (pair_fire),
        .up_data  ({sum_last, sum}),
        .up_ready (up_ready),
        .dn_valid (m_tvalid),
        .dn_data  (dn_pay),
        .dn_ready (m_tready)
    );

    assign m_tdata = dn_pay[DATA_W-1:0];
    assign m_tlast = dn_pay[DATA_W];
    assign m_tkeep = {KEEP_W{1'b1}};
endmodule

// File: rtl/stream_pair_adder_chk.sv
module stream_pair_adder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_tvalid,
    input logic              a_tready,
    input logic              a_tlast,
    input logic              b_tvalid,
    input logic              b_tready,
    input logic              b_tlast,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tlast
);
    // R2: both readies high only when both inputs offer a beat
    a_r2_joint_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (a_tready && b_tready) |-> (a_tvalid && b_tvalid));

    // R5: input A parks after ending its frame alone
    a_r5_park_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_tvalid && a_tready && a_tlast && b_tvalid && b_tready && !b_tlast)
        |=> !a_tready);

    // R5: input B parks after ending its frame alone
    a_r5_park_b: assert property (@(posedge clk) disable iff (!rst_n)
        (b_tvalid && b_tready && b_tlast && a_tvalid && a_tready && !a_tlast)
        |=> !b_tready);

    // R6: the other input drains regardless of the output
    a_r6_drain_open: assert property (@(posedge clk) disable iff (!rst_n)
        (a_tvalid && a_tready && a_tlast && b_tvalid && b_tready && !b_tlast)
        |=> b_tready);

    // R8: output beat held under backpressure
    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R9: output is empty on the first cycle out of reset
    a_r9_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !m_tvalid);
endmodule

bind stream_pair_adder stream_pair_adder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_tvalid (a_tvalid),
    .a_tready (a_tready),
    .a_tlast  (a_tlast),
    .b_tvalid (b_tvalid),
    .b_tready (b_tready),
    .b_tlast  (b_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast)
);

// File: tb/tb_stream_pair_adder.sv
`timescale 1ns/1ps
module tb_stream_pair_adder;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a_tdata = '0;
    logic          a_tlast = 1'b0;
    logic          a_tvalid = 1'b0;
    logic          a_tready;
    logic [W-1:0]  b_tdata = '0;
    logic          b_tlast = 1'b0;
    logic          b_tvalid = 1'b0;
    logic          b_tready;
    logic [W-1:0]  m_tdata;
    logic [W/8-1:0] m_tkeep;
    logic          m_tlast;
    logic          m_tvalid;
    logic          m_tready = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    stream_pair_adder #(.DATA_W(W)) dut (.*);

    typedef struct {
        logic [W-1:0] d;
        logic         l;
    } beat_t;

    beat_t qa[$];
    beat_t qb[$];
    beat_t qe[$];

    int checks = 0;
    int errs   = 0;
    bit done   = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Build all frame-length pairs 1..4 x 1..4 with expected sums
    task automatic build();
        for (int la = 1; la <= 4; la++) begin
            for (int lb = 1; lb <= 4; lb++) begin
                logic [W-1:0] va [4];
                logic [W-1:0] vb [4];
                int lm;
                lm = (la < lb) ? la : lb;
                for (int i = 0; i < 4; i++) begin
                    va[i] = rnd();
                    vb[i] = rnd();
                end
                if (lb % 2 == 0) begin
                    va[0] = 32'hFFFF_FFF0 + la;  // forces wrap
                    vb[0] = 32'h0000_0020;
                end
                for (int i = 0; i < la; i++) qa.push_back('{va[i], i == la - 1});
                for (int i = 0; i < lb; i++) qb.push_back('{vb[i], i == lb - 1});
                for (int i = 0; i < lm; i++) qe.push_back('{va[i] + vb[i], i == lm - 1});
            end
        end
    endtask

    task automatic run_pass(input int mode);
        int  cyc = 0;
        bit  pa = 0, pb = 0;
        int  hold = 0;
        bit  pstall = 0;
        logic [W-1:0] pd = '0;
        logic pl = 1'b0;
        bit  want, ra, rb, fa, fb, fm;
        while ((qa.size() > 0 || qb.size() > 0 || qe.size() > 0 || a_tvalid || b_tvalid)
               && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (pa) begin void'(qa.pop_front()); a_tvalid = 1'b0; end
            if (pb) begin void'(qb.pop_front()); b_tvalid = 1'b0; end
            if (!a_tvalid && qa.size() > 0 && (mode == 0 || rnd() % 3 != 0)) begin
                a_tvalid = 1'b1; a_tdata = qa[0].d; a_tlast = qa[0].l;
            end
            if (!b_tvalid && qb.size() > 0 && (mode == 0 || rnd() % 3 != 0)) begin
                b_tvalid = 1'b1; b_tdata = qb[0].d; b_tlast = qb[0].l;
            end
            want = (mode < 2) ? 1'b1 : rnd() % 2 == 0;
            // R8: readies must not follow m_tready within the cycle
            m_tready = !want;
            #0.5;
            ra = a_tready; rb = b_tready;
            m_tready = want;
            #0.5;
            chk(ra == a_tready && rb == b_tready, "R8", "ready follows m_tready",
                {ra, rb}, {a_tready, b_tready});
            fa = a_tvalid && a_tready;
            fb = b_tvalid && b_tready;
            fm = m_tvalid && m_tready;
            if (hold == 1) begin
                chk(!a_tready, "R5", "parked A ready", a_tready, 0);
                chk(b_tready, "R6", "draining B ready", b_tready, 1);
            end else if (hold == 2) begin
                chk(!b_tready, "R5", "parked B ready", b_tready, 0);
                chk(a_tready, "R6", "draining A ready", a_tready, 1);
            end else begin
                chk(fa == fb, "R2", "joint acceptance", {fa, fb}, {fa, fa});
            end
            if (pstall) begin
                chk(m_tvalid && m_tdata == pd && m_tlast == pl, "R8", "held output",
                    {m_tvalid, m_tlast, m_tdata}, {1'b1, pl, pd});
            end
            pstall = m_tvalid && !m_tready;
            pd = m_tdata; pl = m_tlast;
            if (fm) begin
                if (qe.size() == 0) begin
                    chk(0, "R6", "unexpected output beat", m_tdata, 0);
                end else begin
                    chk(m_tdata == qe[0].d, "R1 R7", "sum", m_tdata, qe[0].d);
                    chk(m_tlast == qe[0].l, "R4", "last", m_tlast, qe[0].l);
                    chk(m_tkeep == 4'hF, "R3", "keep", m_tkeep, 4'hF);
                    void'(qe.pop_front());
                end
            end
            if (hold == 0 && fa && fb) begin
                if (a_tlast && !b_tlast) hold = 1;
                else if (b_tlast && !a_tlast) hold = 2;
            end else if (hold == 1 && fb && b_tlast) begin
                hold = 0;
            end else if (hold == 2 && fa && a_tlast) begin
                hold = 0;
            end
            pa = fa; pb = fb;
        end
        chk(cyc < 4000, "R8", "pass watchdog", cyc, 4000);
        chk(qe.size() == 0, "R8", "missing output beats", qe.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!m_tvalid, "R9", "valid in reset", m_tvalid, 0);
        chk(m_tkeep == 4'hF, "R3", "keep in reset", m_tkeep, 4'hF);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!a_tready && !b_tready, "R2", "idle readies", {a_tready, b_tready}, 0);

        for (int mode = 0; mode < 3; mode++) begin
            build();
            run_pass(mode);
        end

        // R9: reset while input A is parked
        @(negedge clk);
        m_tready = 1'b1;
        a_tvalid = 1'b1; a_tdata = 32'd5; a_tlast = 1'b1;
        b_tvalid = 1'b1; b_tdata = 32'd6; b_tlast = 1'b0;
        @(negedge clk);
        a_tdata = 32'd9; a_tlast = 1'b0;
        b_tdata = 32'd7;
        #1;
        chk(!a_tready, "R5", "A parked before reset", a_tready, 0);
        chk(m_tvalid && m_tdata == 32'd11, "R1", "sum before reset", m_tdata, 32'd11);
        rst_n = 1'b0;
        m_tready = 1'b0;
        @(negedge clk);
        #1;
        chk(!m_tvalid, "R9", "output emptied", m_tvalid, 0);
        rst_n = 1'b1;
        #0.5;
        chk(a_tready && b_tready, "R9", "park cleared", {a_tready, b_tready}, 2'b11);
        @(negedge clk);
        a_tvalid = 1'b0; b_tvalid = 1'b0;
        #1;
        chk(m_tvalid && m_tdata == 32'd16, "R7", "first pair after reset", m_tdata, 32'd16);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule